// File: doc/BRIEF.md
# Switch-Programmed Trainer Memory Front Panel

This block is the glue around a small 8-bit processor trainer. It holds a 128-byte RAM and lets two masters share it. In program mode, a user sets an address and a data byte on toggle switches and presses a deposit button to store the byte by hand. In run mode, the processor bus owns the RAM and may read and write it freely.

The block also runs the front panel. The address indicators show whichever address currently reaches the RAM. The data indicators show the live data bus. A run lamp stays lit for a programmable number of clocks after each instruction-fetch strobe, so short strobes remain visible.

A one-bit output latch is set or cleared only by which address page the bus touches; no data is written to it. Two external input lines are synchronised into the clock domain so that the processor can sample them.

Top module: `trainer_panel`

## Requirements
- R1: The RAM holds 128 bytes of 8 bits. Only bits 6:0 of the selected address choose a location, and all higher address bits are ignored, so addresses 0x0005, 0x0085 and 0xF005 all reach the same byte.
- R2: With `run_mode` low, a rising edge of `deposit` writes `sw_data` at `sw_addr`. A deposit held high writes only once, at its first cycle. The processor address has no effect on the RAM in this mode.
- R3: With `run_mode` high, `deposit` has no effect. A cycle with `cpu_we` high writes `cpu_wdata` at `cpu_addr`.
- R4: `cpu_rdata` returns the byte at the selected address one clock after that address is presented. `cpu_rdata` is forced to 0 while `cpu_we` is high, because the RAM drives the bus only when no write is taking place.
- R5: `addr_led` always equals the address applied to the RAM. This is `cpu_addr` when `run_mode` is high and `sw_addr` otherwise.
- R6: `data_led` shows `cpu_wdata` during a run-mode write. At all other times it shows the registered RAM read data.
- R7: `out_latch` becomes 1 on the clock after the selected address has bit 8 set and bit 9 clear (page 1). It holds its value while bits 9:8 are both clear.
- R8: `out_latch` becomes 0 on the clock after the selected address has bit 9 set (page 2). Clearing wins when bits 8 and 9 are both set, for example at address 0x0300.
- R9: A high `cpu_sync` at a clock edge lights `run_led` for exactly `STRETCH` cycles after that edge. A new strobe reloads the full interval.
- R10: `cpu_flags` follows `in_lines` through two register stages. A change appears after the second clock edge.
- R11: During and directly after reset, `out_latch`, `run_led`, `cpu_rdata` and `cpu_flags` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run_mode | input | 1 | 1 = processor owns RAM, 0 = switches own RAM |
| sw_addr | input | ADDR_W | Address toggle switches |
| sw_data | input | DATA_W | Data toggle switches |
| deposit | input | 1 | Debounced deposit button, level |
| cpu_addr | input | ADDR_W | Processor address bus |
| cpu_wdata | input | DATA_W | Processor write data |
| cpu_we | input | 1 | Processor write strobe, active high |
| cpu_sync | input | 1 | Instruction-fetch strobe |
| cpu_rdata | output | DATA_W | Read data toward processor |
| in_lines | input | 2 | External input lines |
| cpu_flags | output | 2 | Synchronised input lines |
| addr_led | output | ADDR_W | Address indicators |
| data_led | output | DATA_W | Data indicators |
| run_led | output | 1 | Stretched run lamp |
| out_latch | output | 1 | Page-controlled output bit |

## Verification
The bench builds the block with `STRETCH` = 5 in place of the default 65536. This keeps the full run-lamp interval, its expiry on the sixth edge and a mid-interval retrigger within a few dozen cycles. All other parameters stay at their defaults. With a 16-bit address, the tests can reach the aliases above bit 6 and the page-3 address where clearing must win.

// File: rtl/trainer_panel.sv
module trainer_panel #(
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 8,
  parameter int DEPTH   = 128,
  parameter int STRETCH = 65536
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_mode,
  input  logic [ADDR_W-1:0] sw_addr,
  input  logic [DATA_W-1:0] sw_data,
  input  logic              deposit,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  input  logic              cpu_we,
  input  logic              cpu_sync,
  output logic [DATA_W-1:0] cpu_rdata,
  input  logic [1:0]        in_lines,
  output logic [1:0]        cpu_flags,
  output logic [ADDR_W-1:0] addr_led,
  output logic [DATA_W-1:0] data_led,
  output logic              run_led,
  output logic              out_latch
);

  localparam int IDX_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(STRETCH + 1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] ram_q;
  logic [ADDR_W-1:0] addr_sel;
  logic [IDX_W-1:0]  idx;
  logic              dep_q;
  logic              wr_en;
  logic [DATA_W-1:0] wr_data;
  logic [CNT_W-1:0]  cnt;
  logic [1:0]        sync1;
  logic              pg_set, pg_clr;

  assign addr_sel = run_mode ? cpu_addr : sw_addr;
  assign idx      = addr_sel[IDX_W-1:0];
  assign wr_en    = run_mode ? cpu_we : (deposit & ~dep_q);
  assign wr_data  = run_mode ? cpu_wdata : sw_data;
  assign pg_set   = addr_sel[8];
  assign pg_clr   = addr_sel[9];

  always_ff @(posedge clk) begin
    if (wr_en) mem[idx] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ram_q     <= '0;
      dep_q     <= 1'b0;
      cnt       <= '0;
      sync1     <= '0;
      cpu_flags <= '0;
      out_latch <= 1'b0;
    end else begin
      ram_q     <= mem[idx];
      dep_q     <= deposit;
      sync1     <= in_lines;
      cpu_flags <= sync1;
      if (cpu_sync)       cnt <= CNT_W'(STRETCH);
      else if (cnt != '0) cnt <= cnt - 1'b1;
      if (pg_clr)         out_latch <= 1'b0;
      else if (pg_set)    out_latch <= 1'b1;
    end
  end

  assign cpu_rdata = cpu_we ? '0 : ram_q;
  assign addr_led  = addr_sel;
  assign data_led  = (run_mode && cpu_we) ? cpu_wdata : ram_q;
  assign run_led   = (cnt != '0);

  AST_LATCH_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_led[8] && !addr_led[9]) |=> out_latch); // R7
  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!addr_led[8] && !addr_led[9]) |=> $stable(out_latch)); // R7
  AST_LATCH_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    addr_led[9] |=> !out_latch); // R8
  AST_RUN_LED_ON: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_sync |=> run_led); // R9
  AST_RUN_LED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_led && !cpu_sync) |=> !run_led); // R9
  AST_WRITE_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (run_mode && cpu_we) |-> (data_led == cpu_wdata)); // R6

endmodule

// File: tb/tb_trainer_panel.sv
module tb_trainer_panel;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 8;
  localparam logic [23:0] VEC [NVEC] = '{
    24'h0000_11, 24'h0001_22, 24'h007F_A5, 24'h0040_3C,
    24'h0C05_77, 24'h8010_E1, 24'h0020_0F, 24'h0033_F0
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic run_mode = 1'b0;
  logic [15:0] sw_addr = '0;
  logic [7:0]  sw_data = '0;
  logic deposit = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0;
  logic cpu_we = 1'b0;
  logic cpu_sync = 1'b0;
  logic [7:0]  cpu_rdata;
  logic [1:0]  in_lines = '0;
  logic [1:0]  cpu_flags;
  logic [15:0] addr_led;
  logic [7:0]  data_led;
  logic run_led, out_latch;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  trainer_panel #(.STRETCH(5)) dut (
    .clk(clk), .rst_n(rst_n), .run_mode(run_mode), .sw_addr(sw_addr),
    .sw_data(sw_data), .deposit(deposit), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_we(cpu_we), .cpu_sync(cpu_sync),
    .cpu_rdata(cpu_rdata), .in_lines(in_lines), .cpu_flags(cpu_flags),
    .addr_led(addr_led), .data_led(data_led), .run_led(run_led),
    .out_latch(out_latch));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic dep(input logic [15:0] a, input logic [7:0] d);
    run_mode = 1'b0; sw_addr = a; sw_data = d; deposit = 1'b1;
    tick();
    deposit = 1'b0;
    tick();
  endtask

  task automatic rd(input logic [15:0] a, input logic [7:0] exp, input string req);
    run_mode = 1'b1; cpu_we = 1'b0; cpu_addr = a;
    tick();
    chk(req, cpu_rdata, exp);
  endtask

  initial begin
    tick(); tick(); tick();
    chk("R11 latch", out_latch, 0);
    chk("R11 run_led", run_led, 0);
    chk("R11 rdata", cpu_rdata, 0);
    chk("R11 flags", cpu_flags, 0);
    rst_n = 1'b1;
    tick();

    for (int i = 0; i < NVEC; i++) dep(VEC[i][23:8], VEC[i][7:0]);
    for (int i = 0; i < NVEC; i++) rd(VEC[i][23:8], VEC[i][7:0], "R2 deposit/readback");

    dep(16'h0005, 8'h66);
    rd(16'h0085, 8'h66, "R1 alias 0x85");
    rd(16'hF005, 8'h66, "R1 alias 0xF005");

    run_mode = 1'b0; cpu_addr = 16'h1234; sw_addr = 16'h007F;
    #1 chk("R5 addr_led program", addr_led, 16'h007F);
    tick();
    chk("R6 data_led program", data_led, 8'hA5);
    run_mode = 1'b1;
    #1 chk("R5 addr_led run", addr_led, 16'h1234);

    run_mode = 1'b0; sw_addr = 16'h0010; sw_data = 8'hAA; deposit = 1'b1;
    tick();
    sw_data = 8'hBB;
    tick();
    deposit = 1'b0;
    tick();
    rd(16'h0010, 8'hAA, "R2 held deposit writes once");

    run_mode = 1'b0; sw_addr = 16'h0011; sw_data = 8'h12;
    cpu_addr = 16'h0001; deposit = 1'b1;
    tick();
    deposit = 1'b0;
    tick();
    rd(16'h0001, 8'h22, "R2 cpu address ignored in program");
    rd(16'h0011, 8'h12, "R2 switch address used");

    run_mode = 1'b1; sw_addr = 16'h0001; sw_data = 8'h99; cpu_addr = 16'h0050;
    deposit = 1'b1;
    tick();
    deposit = 1'b0;
    tick();
    rd(16'h0001, 8'h22, "R3 deposit ignored in run");

    cpu_addr = 16'h0005; cpu_wdata = 8'h5A; cpu_we = 1'b1;
    #1 chk("R6 data_led on write", data_led, 8'h5A);
    chk("R4 rdata zero on write", cpu_rdata, 0);
    tick();
    cpu_we = 1'b0;
    rd(16'h0005, 8'h5A, "R3 cpu write readback");

    rd(16'h0100, 8'h11, "R1 page1 alias of 0");
    chk("R7 latch set", out_latch, 1);
    rd(16'h0000, 8'h11, "R1 read 0");
    chk("R7 latch hold", out_latch, 1);
    rd(16'h0200, 8'h11, "R1 page2 alias of 0");
    chk("R8 latch clear", out_latch, 0);
    rd(16'h0100, 8'h11, "R1 page1 again");
    rd(16'h0300, 8'h11, "R1 page3 alias of 0");
    chk("R8 clear wins", out_latch, 0);

    cpu_sync = 1'b1;
    tick();
    cpu_sync = 1'b0;
    chk("R9 lit after strobe", run_led, 1);
    repeat (4) tick();
    chk("R9 lit at cycle 5", run_led, 1);
    tick();
    chk("R9 dark at cycle 6", run_led, 0);
    cpu_sync = 1'b1;
    tick();
    cpu_sync = 1'b0;
    repeat (3) tick();
    cpu_sync = 1'b1;
    tick();
    cpu_sync = 1'b0;
    repeat (4) tick();
    chk("R9 retrigger reload", run_led, 1);
    tick();
    chk("R9 retrigger expiry", run_led, 0);

    in_lines = 2'b10;
    tick();
    chk("R10 one edge", cpu_flags, 2'b00);
    tick();
    chk("R10 two edges", cpu_flags, 2'b10);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule